// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial Dot Product (Offset-Binary Table)

This block forms the inner product of K signed input words with K constant coefficients and uses no multiplier. The coefficients are fixed when the design is elaborated. A start pulse captures all K inputs at once. The block then walks through the inputs one bit position per clock, least significant position first.

For each bit position, the K bits of that position are recoded as +1/-1 digits. The top (sign) position takes the opposite polarity. The digits select a precomputed coefficient sum from a table. Because the digit pattern and its complement give sums of equal size and opposite sign, the table keeps only 2^(K-1) entries. The bit of input 0 decides two things: whether the remaining address bits are inverted before the lookup, and whether the adder adds or subtracts the entry. The accumulator starts from a constant offset that depends only on the sum of the coefficients. Each step it adds the selected term and then shifts right arithmetically by one place.

After N steps the result register holds the exact integer sum of C_k·x_k, and a one-cycle done pulse is raised. Reading each input as a fraction x_k/2^(N-1) only rescales the result by 2^(N-1). Start and done are plain control pins with no back-pressure. The caller holds the result for as long as it needs, since the result is stable until the next completion.

Top module: `offset_da_dot`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: For any inputs, the result on completion equals the exact integer value of the sum over k of COEF_k·x_k. Input k occupies bits [k*N +: N] of x_in as N-bit two's complement. Coefficient k occupies bits [k*CW +: CW] of COEF_VEC as CW-bit two's complement.
- R3: With every input at the most negative code (-2^(N-1)), the result equals -2^(N-1) times the coefficient sum.
- R4: With inputs at the positive extreme (2^(N-1)-1), or at a mix of both extremes, the result is exact, with no overflow.
- R5: A start seen while idle produces a done pulse exactly N clock cycles later. The pulse lasts one cycle, and done is never raised at any other time.
- R6: A start seen while a computation is running is ignored. The running computation is neither restarted nor altered, and no extra done pulse follows.
- R7: The result changes only in a cycle where done is 1, and holds its value otherwise.
- R8: A start presented in the same cycle that done is 1 is accepted. Its result follows N cycles later.
- R9: All-zero inputs give 0, and all inputs at -1 give minus the coefficient sum. The constant offset cancels exactly in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture x_in and begin a computation (only when idle) |
| x_in | input | K*N | K two's-complement words, input k at bits [k*N +: N] |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | CW+N+clog2(K)+1 | Signed dot product, held until the next completion |

## Verification
All-zero inputs and all-minus-one inputs show whether the constant offset and the sign-plane polarity are right: they cancel, or give the plain negated coefficient sum, only when both are correct. All inputs at the most negative code, all at the positive maximum, and alternating extremes push the accumulator to its widest values. These patterns expose truncation or width errors in the shift-add path. A single non-zero input isolates one coefficient, so a wrong table address or a swapped add/subtract shows up directly. Random words cover general bit mixes, and starts placed mid-run and in the done cycle separate correct acceptance from restart bugs.

// File: rtl/da_dot_pkg.sv
package da_dot_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // Width of one table word: a sum of K coefficients with +1/-1 weights.
  function automatic int term_width(input int k, input int cw);
    return cw + $clog2(k) + 1;
  endfunction

  // Width of the accumulator and result.
  function automatic int acc_width(input int k, input int n, input int cw);
    return term_width(k, cw) + n;
  endfunction

endpackage

// File: rtl/da_coef_rom.sv
module da_coef_rom #(
  parameter int K  = 4,
  parameter int CW = 10,
  parameter logic [K*CW-1:0] COEF_VEC = '0,
  parameter int TW = 13
) (
  input  logic [K-2:0]          addr,
  output logic signed [TW-1:0]  word
);

  localparam int DEPTH = 1 << (K-1);

  // Entry for digit of input 0 fixed at +1; address bit (k-1) gives the digit of input k.
  function automatic logic signed [TW-1:0] entry_value(input int a);
    logic signed [TW-1:0] s;
    logic signed [CW-1:0] c;
    c = $signed(COEF_VEC[CW-1:0]);
    s = {{(TW-CW){c[CW-1]}}, c};
    for (int k = 1; k < K; k++) begin
      c = $signed(COEF_VEC[k*CW +: CW]);
      if (((a >> (k-1)) & 1) == 1) s = s + {{(TW-CW){c[CW-1]}}, c};
      else                         s = s - {{(TW-CW){c[CW-1]}}, c};
    end
    return s;
  endfunction

  logic signed [TW-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic signed [TW-1:0] VAL = entry_value(i);
    assign table_w[i] = VAL;
  end

  assign word = table_w[addr];

endmodule

// File: rtl/da_plane_sel.sv
module da_plane_sel #(
  parameter int K = 4
) (
  input  logic [K-1:0] plane_bits,
  input  logic         sign_plane,
  output logic [K-2:0] addr,
  output logic         sub
);

  logic [K-1:0] eff;

  always_comb begin
    // The sign position carries negative weight: flip every digit there.
    eff  = plane_bits ^ {K{sign_plane}};
    sub  = ~eff[0];
    addr = sub ? ~eff[K-1:1] : eff[K-1:1];
  end

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
  parameter int AW = 25,
  parameter int TW = 13,
  parameter int N  = 12,
  parameter logic signed [AW-1:0] INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  logic                  sub,
  input  logic signed [TW-1:0]  word,
  output logic signed [AW-1:0]  acc_next
);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] w_ext;
  logic signed [AW-1:0] term;
  logic signed [AW-1:0] sum;

  always_comb begin
    w_ext    = {{(AW-TW){word[TW-1]}}, word};
    term     = sub ? -w_ext : w_ext;
    sum      = acc_q + (term <<< (N-1));
    acc_next = sum >>> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (load)   acc_q <= INIT;
    else if (step)   acc_q <= acc_next;
  end

endmodule

// File: rtl/da_seq_ctrl.sv
module da_seq_ctrl #(
  parameter int N = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic sign_plane,
  output logic finish,
  output logic done
);
  import da_dot_pkg::*;

  localparam int CNTW = (N > 1) ? $clog2(N) : 1;

  seq_state_e      state_q;
  logic [CNTW-1:0] cnt_q;

  always_comb begin
    load       = start && (state_q == ST_IDLE);
    step       = (state_q == ST_RUN);
    sign_plane = (cnt_q == CNTW'(N-1));
    finish     = step && sign_plane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (load) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step) begin
        if (sign_plane) state_q <= ST_IDLE;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/offset_da_dot.sv
module offset_da_dot #(
  parameter int K  = 4,
  parameter int N  = 12,
  parameter int CW = 10,
  parameter logic [K*CW-1:0] COEF_VEC = {10'(-512), 10'(511), 10'(-37), 10'(100)},
  localparam int TW = da_dot_pkg::term_width(K, CW),
  localparam int AW = da_dot_pkg::acc_width(K, N, CW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [K*N-1:0]       x_in,
  output logic                 done,
  output logic signed [AW-1:0] result
);

  function automatic logic signed [AW-1:0] coef_total();
    logic signed [AW-1:0] s;
    logic signed [CW-1:0] c;
    s = '0;
    for (int k = 0; k < K; k++) begin
      c = $signed(COEF_VEC[k*CW +: CW]);
      s = s + {{(AW-CW){c[CW-1]}}, c};
    end
    return s;
  endfunction

  // Offset term: minus the coefficient sum, pre-scaled so that N halvings land it at weight 1/2.
  localparam logic signed [AW-1:0] INIT = -(coef_total() <<< (N-1));

  logic                  load, step, sign_plane, finish;
  logic [K-1:0]          plane_bits;
  logic [K-2:0]          addr;
  logic                  sub;
  logic signed [TW-1:0]  word;
  logic signed [AW-1:0]  acc_next;

  da_seq_ctrl #(.N(N)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .sign_plane(sign_plane),
    .finish(finish), .done(done)
  );

  for (genvar k = 0; k < K; k++) begin : g_lane
    logic [N-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= x_in[k*N +: N];
      else if (step) sh_q <= sh_q >> 1;
    end
    assign plane_bits[k] = sh_q[0];
  end

  da_plane_sel #(.K(K)) sel_i (
    .plane_bits(plane_bits), .sign_plane(sign_plane),
    .addr(addr), .sub(sub)
  );

  da_coef_rom #(.K(K), .CW(CW), .COEF_VEC(COEF_VEC), .TW(TW)) rom_i (
    .addr(addr), .word(word)
  );

  da_shift_acc #(.AW(AW), .TW(TW), .N(N), .INIT(INIT)) acc_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .sub(sub), .word(word), .acc_next(acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result <= '0;
    else if (finish) result <= acc_next;
  end

endmodule

// File: rtl/offset_da_dot_chk.sv
module offset_da_dot_chk #(
  parameter int K  = 4,
  parameter int N  = 12,
  parameter int CW = 10,
  parameter int AW = 25
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 done,
  input logic signed [AW-1:0] result
);

  localparam int  CNTW = $clog2(N+1) + 1;
  localparam longint LIM = longint'(K) * (longint'(1) << (CW-1)) * (longint'(1) << (N-1));

  logic            busy_m;
  logic [CNTW-1:0] cnt_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0;
      cnt_m  <= '0;
    end else begin
      if (done) busy_m <= 1'b0;
      if (start && (!busy_m || done)) begin
        busy_m <= 1'b1;
        cnt_m  <= '0;
      end else if (busy_m && !done) begin
        cnt_m <= cnt_m + 1'b1;
      end
    end
  end

  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_m && cnt_m == CNTW'(N))); // R5
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_m && cnt_m == CNTW'(N)) |-> done); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R7
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (longint'(result) <= LIM && longint'(result) >= -LIM)); // R2

endmodule

bind offset_da_dot offset_da_dot_chk #(.K(K), .N(N), .CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result)
);

// File: tb/offset_da_dot_tb.sv
module offset_da_dot_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int K  = 4;
  localparam int N  = 12;
  localparam int CW = 10;
  localparam int AW = CW + $clog2(K) + 1 + N;
  localparam int C0 = 100, C1 = -37, C2 = 511, C3 = -512;
  localparam logic [K*CW-1:0] CV = {10'(C3), 10'(C2), 10'(C1), 10'(C0)};
  localparam int MINV = -(1 << (N-1));
  localparam int MAXV = (1 << (N-1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [K*N-1:0] x_in = '0;
  logic done;
  logic signed [AW-1:0] result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // reference model state
  bit     m_busy = 0;
  int     m_due = 0;
  longint m_val = 0;
  string  m_tag = "R2";
  bit     exp_done = 0;
  longint exp_res = 0;
  string  exp_tag = "R2";
  string  cur_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_da_dot #(.K(K), .N(N), .CW(CW), .COEF_VEC(CV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .done(done), .result(result)
  );

  function automatic longint coef(input int k);
    case (k)
      0: return C0;
      1: return C1;
      2: return C2;
      default: return C3;
    endcase
  endfunction

  function automatic longint ref_dot(input logic [K*N-1:0] xv);
    longint s = 0;
    for (int k = 0; k < K; k++) begin
      logic signed [N-1:0] w;
      w = xv[k*N +: N];
      s += coef(k) * longint'(w);
    end
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural model, advances on each rising edge
  always @(posedge clk) begin
    bit acc_now;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; exp_done = 0; exp_res = 0;
    end else begin
      acc_now = start && !m_busy;
      exp_done = 0;
      if (m_busy && cyc == m_due) begin
        m_busy = 0; exp_done = 1; exp_res = m_val; exp_tag = m_tag;
      end
      if (start && !m_busy) acc_now = 1;
      if (acc_now) begin
        m_busy = 1; m_due = cyc + N; m_val = ref_dot(x_in); m_tag = cur_tag;
      end
    end
  end

  // compare every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5", longint'(done), longint'(exp_done));
      if (exp_done) check(exp_tag, longint'(result), exp_res);
      else          check("R7", longint'(result), exp_res);
    end
  end

  task automatic issue(input int v0, input int v1, input int v2, input int v3, input string tag);
    @(negedge clk);
    cur_tag = tag;
    x_in = {N'(v3), N'(v2), N'(v1), N'(v0)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int v0, input int v1, input int v2, input int v3, input string tag);
    issue(v0, v1, v2, v3, tag);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", longint'(done), 0);
    check("R1", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(0, 0, 0, 0, "R9");
    run(-1, -1, -1, -1, "R9");
    run(MINV, MINV, MINV, MINV, "R3");
    run(MAXV, MAXV, MAXV, MAXV, "R4");
    run(MAXV, MINV, MAXV, MINV, "R4");
    run(MINV, MAXV, MINV, MAXV, "R4");
    run(1, 0, 0, 0, "R2");
    run(0, 0, 0, MINV, "R2");
    run(0, 0, 5, 0, "R2");
    for (int i = 0; i < 40; i++) begin
      run(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048,
          int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048, "R2");
    end

    // R6: second start during a run must be ignored
    issue(123, -456, 789, -1000, "R6");
    repeat (3) @(negedge clk);
    issue(MAXV, MAXV, MAXV, MAXV, "R6");
    wait_idle();

    // R8: start presented in the done cycle
    issue(-7, 300, -2000, 17, "R8");
    repeat (N-1) @(negedge clk);
    issue(MINV, 1, MAXV, -1, "R8");
    wait_idle();
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule